// File: doc/BRIEF.md
# Dual Data Pointer Register Unit

This unit keeps two 16-bit pointers into external data space for an 8051-style core, together with a one-bit register that chooses between them. The special-function-register bus can reach every byte of both pointers and the select register. The core side can load the active pointer as one 16-bit word, or step it by one. The active pointer always drives the external data address.

Block moves are the intended use. Software points one pointer at the source and the other at the destination. It then flips the select bit with a single increment of the select register between each read and each write. This way it never has to save and restore addresses. Load and increment act only on the selected pointer; the other pointer keeps its value until it is selected again.

Top module: `dptr_unit`

## Requirements
- R1: After a synchronous active-low reset, both pointers hold 0000h, the select bit is 0 and `xaddr` is 0000h.
- R2: Register bus addresses 82h/83h are the low/high bytes of pointer 0, and 84h/85h are those of pointer 1. A byte write lands on the next rising clock edge. `sfr_rdata` shows the addressed byte combinationally.
- R3: Bit 0 of address 86h is the select bit (0 selects pointer 0, 1 selects pointer 1). Bits 7..1 of 86h always read 0, whatever was written.
- R4: `sfr_inc` with `sfr_addr` = 86h inverts the select bit on the next edge. A write to 86h in the same cycle takes precedence over the inversion. `sfr_inc` at any other address changes nothing.
- R5: `ld_en` replaces both bytes of the selected pointer with `ld_val` on the next edge.
- R6: `ptr_inc` adds one to the selected 16-bit pointer with carry from the low byte into the high byte. FFFFh becomes 0000h.
- R7: When `ld_en` and `ptr_inc` are both high, the pointer takes `ld_val` and is not incremented.
- R8: The unselected pointer is not changed by `ld_en` or `ptr_inc`.
- R9: `xaddr` always equals the pointer selected by the current select bit.
- R10: Reads of any address other than 82h..86h return 00h.
- R11: In a cycle where `ld_en` or `ptr_inc` acts on the selected pointer, a register bus byte write to that same pointer is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| sfr_addr | input | 8 | Register bus address |
| sfr_wdata | input | 8 | Register bus write byte |
| sfr_we | input | 1 | Register bus write enable |
| sfr_inc | input | 1 | Increment strobe for the addressed register (acts at 86h) |
| sfr_rdata | output | 8 | Register bus read byte |
| ld_en | input | 1 | Load the selected pointer from `ld_val` |
| ld_val | input | 16 | 16-bit load value |
| ptr_inc | input | 1 | Increment the selected pointer |
| xaddr | output | 16 | External data address (selected pointer) |
| dp_sel | output | 1 | Current select bit |

## Verification
The bench drives an interleaved block move that starts near FFFFh. Two failures show up in this move: a carry that fails to ripple or wrap breaks the address sequence, and steering an increment to the wrong pointer makes the two sequences interfere. Simultaneous load and increment are run to catch a design that adds one after loading. A design that lets a register-bus byte overwrite a core update fails the same-cycle write-versus-increment check, and so does a design that lets an increment beat a write on 86h. Random traffic over 80h..88h catches non-zero upper select bits and stray data on unmapped reads.

// File: rtl/dptr_pkg.sv
// Package: shared sizes and register bus addresses for the dual data pointer unit.
// Assumes an 8-bit register bus and pointers that are a whole number of bytes wide.
package dptr_pkg;
    parameter int PTR_W   = 16;
    parameter int BYTE_W  = 8;
    parameter int NPTR    = 2;               // fixed by the one-bit select register
    localparam int NBYTES = PTR_W / BYTE_W;
    parameter logic [7:0] PTR_BASE = 8'h82;  // pointer k byte b sits at PTR_BASE + NBYTES*k + b
    parameter logic [7:0] SEL_ADDR = 8'h86;
endpackage

// File: rtl/dptr_reg.sv
// Module: one data pointer. Core load wins over core increment; both win over
// register bus byte writes. Core operations only act when this pointer is selected.
module dptr_reg #(
    parameter int W  = 16,
    parameter int BW = 8,
    localparam int NB = W / BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_me,
    input  logic          ld,
    input  logic [W-1:0]  ld_val,
    input  logic          inc,
    input  logic [NB-1:0] bwe,
    input  logic [BW-1:0] bdata,
    output logic [W-1:0]  q
);
    logic core_op;
    assign core_op = sel_me && (ld || inc);

    // Pointer register: reset, load, increment or byte writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (sel_me && ld) begin
            q <= ld_val;
        end else if (sel_me && inc) begin
            q <= q + 1'b1;
        end else begin
            for (int b = 0; b < NB; b++) begin
                if (bwe[b]) q[b*BW +: BW] <= bdata;
            end
        end
    end

    // R5 R7
    load_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_me && ld |=> q == $past(ld_val));
    // R6
    inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_me && inc && !ld |=> q == $past(q) + 1'b1);
    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_me && (bwe == '0) |=> $stable(q));
    // R11
    core_over_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_op && (bwe != '0) && !ld |=> q == $past(q) + 1'b1);
endmodule

// File: rtl/dptr_sel.sv
// Module: one-bit pointer select register. A bus write sets it from bit 0 of the
// write data; an increment strobe inverts it; a write in the same cycle wins.
module dptr_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic wbit,
    input  logic flip,
    output logic sel
);
    // Select register update.
    always_ff @(posedge clk) begin
        if (!rst_n)    sel <= 1'b0;
        else if (wr)   sel <= wbit;
        else if (flip) sel <= ~sel;
    end

    // R4
    flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flip && !wr |=> sel != $past(sel));
    // R4
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> sel == $past(wbit));
endmodule

// File: rtl/dptr_unit.sv
// Module: top of the dual data pointer unit. Decodes the register bus onto the
// pointer bytes and the select register, muxes read data, and drives the selected
// pointer as the external data address. Assumes core strobes are single-cycle.
module dptr_unit
    import dptr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        sfr_addr,
    input  logic [BYTE_W-1:0] sfr_wdata,
    input  logic              sfr_we,
    input  logic              sfr_inc,
    output logic [BYTE_W-1:0] sfr_rdata,
    input  logic              ld_en,
    input  logic [PTR_W-1:0]  ld_val,
    input  logic              ptr_inc,
    output logic [PTR_W-1:0]  xaddr,
    output logic              dp_sel
);
    logic [PTR_W-1:0] ptr_q [NPTR];
    logic             hit_sel;

    assign hit_sel = (sfr_addr == SEL_ADDR);

    for (genvar k = 0; k < NPTR; k++) begin : g_ptr
        logic [NBYTES-1:0] bwe;
        for (genvar b = 0; b < NBYTES; b++) begin : g_byte
            assign bwe[b] = sfr_we && (sfr_addr == PTR_BASE + 8'(NBYTES*k + b));
        end
        dptr_reg #(.W(PTR_W), .BW(BYTE_W)) u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .sel_me (dp_sel == 1'(k)),
            .ld     (ld_en),
            .ld_val (ld_val),
            .inc    (ptr_inc),
            .bwe    (bwe),
            .bdata  (sfr_wdata),
            .q      (ptr_q[k])
        );
    end

    dptr_sel u_sel (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (sfr_we && hit_sel),
        .wbit  (sfr_wdata[0]),
        .flip  (sfr_inc && hit_sel),
        .sel   (dp_sel)
    );

    assign xaddr = ptr_q[dp_sel];

    // Read mux: pointer bytes, select register with upper bits zero, else zero.
    always_comb begin
        sfr_rdata = '0;
        for (int k = 0; k < NPTR; k++) begin
            for (int b = 0; b < NBYTES; b++) begin
                if (sfr_addr == PTR_BASE + 8'(NBYTES*k + b)) sfr_rdata = ptr_q[k][b*BYTE_W +: BYTE_W];
            end
        end
        if (hit_sel) sfr_rdata = {{(BYTE_W-1){1'b0}}, dp_sel};
    end

    // R3
    sel_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_sel |-> sfr_rdata[BYTE_W-1:1] == '0);
    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_addr < PTR_BASE || sfr_addr > SEL_ADDR) |-> sfr_rdata == '0);
    // R4
    other_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sfr_we && hit_sel) && !(sfr_inc && hit_sel) |=> $stable(dp_sel));
endmodule

// File: tb/dptr_unit_test.sv
module dptr_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  sfr_addr = 8'h00, sfr_wdata = 8'h00, sfr_rdata;
    logic        sfr_we = 1'b0, sfr_inc = 1'b0, ld_en = 1'b0, ptr_inc = 1'b0, dp_sel;
    logic [15:0] ld_val = 16'h0000, xaddr;

    int total = 0, bad = 0;
    logic [15:0] m_p0 = 16'h0, m_p1 = 16'h0;
    logic        m_sel = 1'b0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    dptr_unit uut (.*);

    task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // Expected next state from the requirements.
    task automatic model(logic we, logic [7:0] a, logic [7:0] wd, logic si,
                         logic ld, logic [15:0] lv, logic inc);
        logic [15:0] n0 = m_p0, n1 = m_p1;
        logic        ns = m_sel;
        if (m_sel == 1'b0 && ld)       n0 = lv;
        else if (m_sel == 1'b0 && inc) n0 = m_p0 + 16'd1;
        else if (we && a == 8'h82)     n0[7:0] = wd;
        else if (we && a == 8'h83)     n0[15:8] = wd;
        if (m_sel == 1'b1 && ld)       n1 = lv;
        else if (m_sel == 1'b1 && inc) n1 = m_p1 + 16'd1;
        else if (we && a == 8'h84)     n1[7:0] = wd;
        else if (we && a == 8'h85)     n1[15:8] = wd;
        if (we && a == 8'h86)          ns = wd[0];
        else if (si && a == 8'h86)     ns = ~m_sel;
        m_p0 = n0; m_p1 = n1; m_sel = ns;
    endtask

    // One clock with the given stimulus; inputs change on the falling edge.
    task automatic step(logic we, logic [7:0] a, logic [7:0] wd, logic si,
                        logic ld, logic [15:0] lv, logic inc);
        @(negedge clk);
        sfr_we = we; sfr_addr = a; sfr_wdata = wd; sfr_inc = si;
        ld_en = ld; ld_val = lv; ptr_inc = inc;
        @(posedge clk);
        model(we, a, wd, si, ld, lv, inc);
        #2;
        sfr_we = 0; sfr_inc = 0; ld_en = 0; ptr_inc = 0;
    endtask

    task automatic rd(logic [7:0] a, logic [7:0] exp, string req);
        sfr_addr = a;
        #1;
        chk(req, {8'h00, sfr_rdata}, {8'h00, exp});
    endtask

    // Full visible state check between edges.
    task automatic check_all();
        chk("R9 xaddr", xaddr, m_sel ? m_p1 : m_p0);
        rd(8'h82, m_p0[7:0], "R2 p0 lo");
        rd(8'h83, m_p0[15:8], "R2 p0 hi");
        rd(8'h84, m_p1[7:0], "R2 p1 lo");
        rd(8'h85, m_p1[15:8], "R2 p1 hi");
        rd(8'h86, {7'b0, m_sel}, "R3 sel reg");
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state
        chk("R1 xaddr", xaddr, 16'h0000);
        chk("R1 sel", {15'b0, dp_sel}, 16'h0);
        rd(8'h82, 8'h00, "R1 p0 lo"); rd(8'h85, 8'h00, "R1 p1 hi");
        @(negedge clk); rst_n = 1'b1;

        // R2 byte writes and R3 upper bits ignored
        step(1, 8'h84, 8'hCD, 0, 0, 0, 0);
        step(1, 8'h85, 8'hAB, 0, 0, 0, 0);
        step(1, 8'h86, 8'hFF, 0, 0, 0, 0);
        rd(8'h86, 8'h01, "R3 upper bits read 0");
        chk("R2 R9 p1 bytes", xaddr, 16'hABCD);
        // R4 increment at 86h flips; elsewhere no effect
        step(0, 8'h86, 8'h00, 1, 0, 0, 0);
        chk("R4 flip to p0", {15'b0, dp_sel}, 16'h0);
        step(0, 8'h84, 8'h00, 1, 0, 0, 0);
        chk("R4 inc elsewhere", {15'b0, dp_sel}, 16'h0);
        rd(8'h84, 8'hCD, "R4 inc elsewhere byte");
        step(1, 8'h86, 8'h00, 1, 0, 0, 0);
        chk("R4 write wins", {15'b0, dp_sel}, 16'h0);
        // R5 load, R8 other kept
        step(0, 8'h00, 8'h00, 0, 1, 16'h1234, 0);
        chk("R5 load", xaddr, 16'h1234);
        rd(8'h85, 8'hAB, "R8 p1 kept on load");
        // R7 load beats increment
        step(0, 8'h00, 8'h00, 0, 1, 16'h5555, 1);
        chk("R7 load wins", xaddr, 16'h5555);
        // R6 carry and wrap
        step(0, 8'h00, 8'h00, 0, 1, 16'h00FF, 0);
        step(0, 8'h00, 8'h00, 0, 0, 0, 1);
        chk("R6 carry", xaddr, 16'h0100);
        step(0, 8'h00, 8'h00, 0, 1, 16'hFFFF, 0);
        step(0, 8'h00, 8'h00, 0, 0, 0, 1);
        chk("R6 wrap", xaddr, 16'h0000);
        rd(8'h84, 8'hCD, "R8 p1 kept on inc");
        // R11 core op beats bus byte write to the selected pointer
        step(1, 8'h82, 8'h77, 0, 0, 0, 1);
        chk("R11 inc over byte write", xaddr, 16'h0001);
        // R10 unmapped reads
        rd(8'h81, 8'h00, "R10 81h"); rd(8'h87, 8'h00, "R10 87h"); rd(8'hFF, 8'h00, "R10 FFh");
        check_all();

        // Block move: source via p0, destination via p1, starting near wrap
        step(0, 8'h00, 8'h00, 0, 1, 16'hFFFC, 0);
        step(1, 8'h86, 8'h01, 0, 0, 0, 0);
        step(0, 8'h00, 8'h00, 0, 1, 16'h4000, 0);
        step(1, 8'h86, 8'h00, 0, 0, 0, 0);
        for (int i = 0; i < 8; i++) begin
            chk("R9 R6 move src", xaddr, 16'hFFFC + 16'(i));
            step(0, 8'h00, 8'h00, 0, 0, 0, 1);
            step(0, 8'h86, 8'h00, 1, 0, 0, 0);
            chk("R9 R8 move dst", xaddr, 16'h4000 + 16'(i));
            step(0, 8'h00, 8'h00, 0, 0, 0, 1);
            step(0, 8'h86, 8'h00, 1, 0, 0, 0);
        end
        check_all();

        // Random traffic against the model
        for (int n = 0; n < 400; n++) begin
            logic [7:0] a;
            a = 8'h80 + 8'($urandom_range(0, 8));
            step(1'($urandom_range(0, 1)), a, 8'($urandom), 1'($urandom_range(0, 1)),
                 ($urandom_range(0, 5) == 0), 16'($urandom), 1'($urandom_range(0, 1)));
            check_all();
            rd(8'h88, 8'h00, "R10 random unmapped");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule